// File: doc/BRIEF.md
# Speculative Read-Set Line Tracker

This block records, for each hardware strand, which lines of a data cache have been read while that strand runs ahead speculatively or runs a hardware transaction. Every load that hits the cache during speculation marks the addressed line for the strand that issued it. The loads may arrive out of program order. Later, if the cache reports that a marked line was invalidated by a remote writer or evicted by a local replacement, the block raises a one-cycle failure pulse for that strand. This tells the surrounding pipeline that load atomicity is lost and the strand must roll back to its checkpoint.

When a strand's speculative episode ends, the surrounding logic issues a clear for that strand. An episode ends by a join, a fail or a transaction commit. The clear wipes every mark the strand holds in one cycle. Each strand's marks live in their own line-wide vector, so a clear is a single reset of that vector. A strand's speculation flag gates both marking and failure reporting.

Top module: `spec_rdset_tracker`

## Requirements
- R1: A load (`ld_valid`=1) issued by strand s while `spec_active[s]`=1 marks line `ld_line` for strand s only. A later invalidation of that line raises `fail_pulse[s]` and leaves the bit for the other strand low.
- R2: An invalidation (`inv_valid`=1) of a line marked for a speculating strand s sets `fail_pulse[s]` on the clock edge that samples the invalidation. Bit s of `fail_pulse` is strand s.
- R3: A replacement (`repl_valid`=1) of a marked line behaves like an invalidation, on every line index from 0 to the last line.
- R4: An invalidation or replacement of a line not marked for strand s gives no pulse for s. A cycle with neither event gives no pulse on any strand.
- R5: A clear (`clr_valid`=1, `clr_strand`=s) removes every mark of strand s in one cycle and leaves the marks of the other strands intact.
- R6: A load and an invalidation or replacement of the same line, in the same cycle and by a speculating strand, raise that strand's pulse.
- R7: While `spec_active[s]`=0, strand s gets no pulse and its loads mark nothing.
- R8: A pulse lasts one cycle. An invalidated or replaced line loses its marks for all strands, so a repeated event on that line gives no new pulse.
- R9: A clear for strand s wins over a coincident event or load for s. No pulse is raised, and the coincident load leaves no mark.
- R10: A synchronous active-high reset removes all marks and holds `fail_pulse` at zero.
- R11: An invalidation and a replacement in the same cycle that both hit marks of strand s give a single one-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| spec_active | input | STRANDS | Strand is speculating, one bit per strand |
| ld_valid | input | 1 | Speculative load hit this cycle |
| ld_line | input | LW | Line index of the load |
| ld_strand | input | SW | Strand issuing the load |
| inv_valid | input | 1 | Line invalidated this cycle |
| inv_line | input | LW | Invalidated line index |
| repl_valid | input | 1 | Line evicted this cycle |
| repl_line | input | LW | Evicted line index |
| clr_valid | input | 1 | Join, fail or commit clear this cycle |
| clr_strand | input | SW | Strand being cleared |
| fail_pulse | output | STRANDS | One-cycle speculation failure, per strand |

## Verification
A stuck or lost mark shows up at the ports only when that line is invalidated or evicted. The bench therefore marks lines and then probes them with events, and it checks `fail_pulse` one edge after each probe. A mark that is missing, extra, or attributed to the wrong strand appears in that same cycle as a wrong pulse bit. A clear or reset that fails to wipe marks appears at the next probe of a line marked before it. Lines 0 and 511 are probed to catch indexing faults at the ends of the vector.

// File: rtl/spec_rdset_pkg.sv
package spec_rdset_pkg;

    localparam int unsigned DEF_LINES   = 512;
    localparam int unsigned DEF_STRANDS = 2;

    // Event of one cycle aimed at a given strand
    function automatic logic aimed_at(input logic valid, input logic [31:0] id,
                                      input int unsigned s);
        return valid && (id == s);
    endfunction

endpackage

// File: rtl/spec_rdset_dec.sv
module spec_rdset_dec #(
    parameter int unsigned N = 512,
    localparam int unsigned W = (N > 1) ? $clog2(N) : 1
) (
    input  logic         en,
    input  logic [W-1:0] idx,
    output logic [N-1:0] onehot
);
    always_comb begin
        onehot = '0;
        if (en) onehot[idx] = 1'b1;
    end
endmodule

// File: rtl/spec_rdset_strand.sv
module spec_rdset_strand #(
    parameter int unsigned N = 512
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         active,
    input  logic         load_mine,
    input  logic [N-1:0] load_vec,
    input  logic [N-1:0] kill_vec,
    input  logic         clr,
    output logic         fail_q
);
    logic [N-1:0] marks_q, marks_d;
    logic         hit;

    always_comb begin
        hit = |(kill_vec & (marks_q | (load_mine ? load_vec : '0)));
        if (clr)
            marks_d = '0;
        else
            marks_d = (marks_q | ((load_mine && active) ? load_vec : '0)) & ~kill_vec;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            marks_q <= '0;
            fail_q  <= 1'b0;
        end else begin
            marks_q <= marks_d;
            fail_q  <= active && hit && !clr;
        end
    end
endmodule

// File: rtl/spec_rdset_tracker.sv
module spec_rdset_tracker
    import spec_rdset_pkg::*;
#(
    parameter int unsigned LINES   = DEF_LINES,
    parameter int unsigned STRANDS = DEF_STRANDS,
    localparam int unsigned LW = (LINES > 1) ? $clog2(LINES) : 1,
    localparam int unsigned SW = (STRANDS > 1) ? $clog2(STRANDS) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [STRANDS-1:0] spec_active,
    input  logic               ld_valid,
    input  logic [LW-1:0]      ld_line,
    input  logic [SW-1:0]      ld_strand,
    input  logic               inv_valid,
    input  logic [LW-1:0]      inv_line,
    input  logic               repl_valid,
    input  logic [LW-1:0]      repl_line,
    input  logic               clr_valid,
    input  logic [SW-1:0]      clr_strand,
    output logic [STRANDS-1:0] fail_pulse
);
    logic [LINES-1:0] load_vec, inv_vec, repl_vec, kill_vec;

    spec_rdset_dec #(.N(LINES)) u_dec_ld  (.en(ld_valid),   .idx(ld_line),   .onehot(load_vec));
    spec_rdset_dec #(.N(LINES)) u_dec_inv (.en(inv_valid),  .idx(inv_line),  .onehot(inv_vec));
    spec_rdset_dec #(.N(LINES)) u_dec_rep (.en(repl_valid), .idx(repl_line), .onehot(repl_vec));

    assign kill_vec = inv_vec | repl_vec;

    for (genvar s = 0; s < STRANDS; s++) begin : g_strand
        logic load_mine, clr_mine;
        assign load_mine = aimed_at(ld_valid,  32'(ld_strand),  s);
        assign clr_mine  = aimed_at(clr_valid, 32'(clr_strand), s);

        spec_rdset_strand #(.N(LINES)) u_strand (
            .clk      (clk),
            .rst      (rst),
            .active   (spec_active[s]),
            .load_mine(load_mine),
            .load_vec (load_vec),
            .kill_vec (kill_vec),
            .clr      (clr_mine),
            .fail_q   (fail_pulse[s])
        );
    end
endmodule

// File: rtl/spec_rdset_checker.sv
module spec_rdset_checker #(
    parameter int unsigned LINES   = 512,
    parameter int unsigned STRANDS = 2,
    localparam int unsigned LW = (LINES > 1) ? $clog2(LINES) : 1,
    localparam int unsigned SW = (STRANDS > 1) ? $clog2(STRANDS) : 1
) (
    input logic               clk,
    input logic               rst,
    input logic [STRANDS-1:0] spec_active,
    input logic               ld_valid,
    input logic [LW-1:0]      ld_line,
    input logic [SW-1:0]      ld_strand,
    input logic               inv_valid,
    input logic [LW-1:0]      inv_line,
    input logic               repl_valid,
    input logic [LW-1:0]      repl_line,
    input logic               clr_valid,
    input logic [SW-1:0]      clr_strand,
    input logic [STRANDS-1:0] fail_pulse
);
    AST_RESET_CLEAN: assert property (@(posedge clk) rst |=> fail_pulse == '0); // R10

    AST_NO_EVENT_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!inv_valid && !repl_valid) |=> fail_pulse == '0); // R4

    for (genvar s = 0; s < STRANDS; s++) begin : g_chk
        AST_IDLE_STRAND_QUIET: assert property (@(posedge clk) disable iff (rst)
            !spec_active[s] |=> !fail_pulse[s]); // R7

        AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
            (clr_valid && clr_strand == SW'(s)) |=> !fail_pulse[s]); // R9

        AST_SAME_CYCLE_FAIL: assert property (@(posedge clk) disable iff (rst)
            (spec_active[s] && ld_valid && ld_strand == SW'(s)
             && !(clr_valid && clr_strand == SW'(s))
             && ((inv_valid && inv_line == ld_line) || (repl_valid && repl_line == ld_line)))
            |=> fail_pulse[s]); // R6
    end
endmodule

bind spec_rdset_tracker spec_rdset_checker #(.LINES(LINES), .STRANDS(STRANDS)) u_chk (
    .clk(clk), .rst(rst), .spec_active(spec_active),
    .ld_valid(ld_valid), .ld_line(ld_line), .ld_strand(ld_strand),
    .inv_valid(inv_valid), .inv_line(inv_line),
    .repl_valid(repl_valid), .repl_line(repl_line),
    .clr_valid(clr_valid), .clr_strand(clr_strand),
    .fail_pulse(fail_pulse)
);

// File: tb/tb_spec_rdset_tracker.sv
module tb_spec_rdset_tracker;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] spec_active = 2'b11;
    logic       ld_valid = 1'b0;
    logic [8:0] ld_line = '0;
    logic       ld_strand = 1'b0;
    logic       inv_valid = 1'b0;
    logic [8:0] inv_line = '0;
    logic       repl_valid = 1'b0;
    logic [8:0] repl_line = '0;
    logic       clr_valid = 1'b0;
    logic       clr_strand = 1'b0;
    logic [1:0] fail_pulse;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    spec_rdset_tracker dut (
        .clk(clk), .rst(rst), .spec_active(spec_active),
        .ld_valid(ld_valid), .ld_line(ld_line), .ld_strand(ld_strand),
        .inv_valid(inv_valid), .inv_line(inv_line),
        .repl_valid(repl_valid), .repl_line(repl_line),
        .clr_valid(clr_valid), .clr_strand(clr_strand),
        .fail_pulse(fail_pulse)
    );

    typedef struct packed {
        logic [1:0] spec;
        logic       ldv;  logic [8:0] ldl; logic lds;
        logic       iv;   logic [8:0] il;
        logic       rv;   logic [8:0] rl;
        logic       cv;   logic       cs;
        logic [1:0] exp;
        logic [7:0] req;
    } vec_t;

    localparam int NV = 30;
    localparam vec_t VEC [NV] = '{
        '{2'b11, 1, 9'd5,   0, 0, 9'd0,   0, 9'd0,   0, 0, 2'b00, 8'd1},  // R1 mark s0 line 5
        '{2'b11, 1, 9'd7,   1, 0, 9'd0,   0, 9'd0,   0, 0, 2'b00, 8'd1},  // R1 mark s1 line 7
        '{2'b11, 0, 9'd0,   0, 1, 9'd5,   0, 9'd0,   0, 0, 2'b01, 8'd2},  // R2 inv hits s0 only
        '{2'b11, 0, 9'd0,   0, 1, 9'd5,   0, 9'd0,   0, 0, 2'b00, 8'd8},  // R8 repeat inv
        '{2'b11, 0, 9'd0,   0, 0, 9'd0,   1, 9'd7,   0, 0, 2'b10, 8'd3},  // R3 repl hits s1
        '{2'b11, 1, 9'd511, 0, 0, 9'd0,   0, 9'd0,   0, 0, 2'b00, 8'd3},  // R3 mark last line
        '{2'b11, 0, 9'd0,   0, 1, 9'd100, 0, 9'd0,   0, 0, 2'b00, 8'd4},  // R4 unmarked line
        '{2'b11, 0, 9'd0,   0, 0, 9'd0,   1, 9'd511, 0, 0, 2'b01, 8'd3},  // R3 last line evicted
        '{2'b11, 1, 9'd0,   1, 0, 9'd0,   0, 9'd0,   0, 0, 2'b00, 8'd1},  // R1 s1 line 0
        '{2'b11, 1, 9'd0,   0, 1, 9'd0,   0, 9'd0,   0, 0, 2'b11, 8'd6},  // R6 s0 load+inv, s1 marked
        '{2'b11, 1, 9'd3,   0, 0, 9'd0,   0, 9'd0,   0, 0, 2'b00, 8'd5},  // R5 mark s0 line 3
        '{2'b11, 0, 9'd0,   0, 0, 9'd0,   0, 9'd0,   1, 0, 2'b00, 8'd5},  // R5 clear s0
        '{2'b11, 0, 9'd0,   0, 1, 9'd3,   0, 9'd0,   0, 0, 2'b00, 8'd5},  // R5 cleared line quiet
        '{2'b11, 1, 9'd9,   1, 0, 9'd0,   0, 9'd0,   0, 0, 2'b00, 8'd5},  // R5 s1 line 9
        '{2'b11, 1, 9'd9,   0, 0, 9'd0,   0, 9'd0,   0, 0, 2'b00, 8'd5},  // R5 s0 line 9
        '{2'b11, 0, 9'd0,   0, 0, 9'd0,   0, 9'd0,   1, 0, 2'b00, 8'd5},  // R5 clear s0
        '{2'b11, 0, 9'd0,   0, 1, 9'd9,   0, 9'd0,   0, 0, 2'b10, 8'd5},  // R5 s1 kept its mark
        '{2'b01, 1, 9'd20,  1, 0, 9'd0,   0, 9'd0,   0, 0, 2'b00, 8'd7},  // R7 idle s1 load
        '{2'b11, 0, 9'd0,   0, 1, 9'd20,  0, 9'd0,   0, 0, 2'b00, 8'd7},  // R7 no mark made
        '{2'b11, 1, 9'd30,  0, 0, 9'd0,   0, 9'd0,   0, 0, 2'b00, 8'd7},  // R7 s0 line 30
        '{2'b10, 0, 9'd0,   0, 1, 9'd30,  0, 9'd0,   0, 0, 2'b00, 8'd7},  // R7 s0 idle, suppressed
        '{2'b11, 1, 9'd40,  0, 0, 9'd0,   0, 9'd0,   0, 0, 2'b00, 8'd9},  // R9 s0 line 40
        '{2'b11, 0, 9'd0,   0, 1, 9'd40,  0, 9'd0,   1, 0, 2'b00, 8'd9},  // R9 clear+inv
        '{2'b11, 0, 9'd0,   0, 1, 9'd40,  0, 9'd0,   0, 0, 2'b00, 8'd9},  // R9 gone after
        '{2'b11, 1, 9'd50,  1, 0, 9'd0,   0, 9'd0,   1, 1, 2'b00, 8'd9},  // R9 clear+load s1
        '{2'b11, 0, 9'd0,   0, 1, 9'd50,  0, 9'd0,   0, 0, 2'b00, 8'd9},  // R9 load dropped
        '{2'b11, 1, 9'd60,  0, 0, 9'd0,   0, 9'd0,   0, 0, 2'b00, 8'd11}, // R11 s0 line 60
        '{2'b11, 1, 9'd61,  0, 0, 9'd0,   0, 9'd0,   0, 0, 2'b00, 8'd11}, // R11 s0 line 61
        '{2'b11, 0, 9'd0,   0, 1, 9'd60,  1, 9'd61,  0, 0, 2'b01, 8'd11}, // R11 both hit
        '{2'b11, 0, 9'd0,   0, 0, 9'd0,   0, 9'd0,   0, 0, 2'b00, 8'd8}   // R8 pulse is one cycle
    };

    task automatic check(input logic [1:0] exp, input int req, input string what);
        total++;
        if (fail_pulse !== exp) begin
            bad++;
            $display("FAIL R%0d %s: fail_pulse=%b expected=%b", req, what, fail_pulse, exp);
        end
    endtask

    task automatic idle();
        ld_valid = 0; inv_valid = 0; repl_valid = 0; clr_valid = 0;
    endtask

    initial begin
        #(20 * 100000);
        bad++;
        $display("FAIL watchdog: run=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(2'b00, 10, "during reset"); // R10
        rst = 1'b0;
        for (int i = 0; i < NV; i++) begin
            spec_active = VEC[i].spec;
            ld_valid = VEC[i].ldv; ld_line = VEC[i].ldl; ld_strand = VEC[i].lds;
            inv_valid = VEC[i].iv; inv_line = VEC[i].il;
            repl_valid = VEC[i].rv; repl_line = VEC[i].rl;
            clr_valid = VEC[i].cv; clr_strand = VEC[i].cs;
            @(negedge clk);
            check(VEC[i].exp, int'(VEC[i].req), $sformatf("row %0d", i));
        end
        idle();
        spec_active = 2'b11;
        // R10: marks dropped by reset
        ld_valid = 1; ld_line = 9'd70; ld_strand = 0;
        @(negedge clk);
        check(2'b00, 10, "mark before reset");
        idle(); rst = 1'b1;
        @(negedge clk);
        check(2'b00, 10, "reset mid-run");
        rst = 1'b0;
        inv_valid = 1; inv_line = 9'd70;
        @(negedge clk);
        check(2'b00, 10, "probe after reset");
        idle();
        // R2: back-to-back events on two marked lines pulse twice
        ld_valid = 1; ld_line = 9'd80; ld_strand = 1;
        @(negedge clk);
        ld_line = 9'd81;
        @(negedge clk);
        ld_valid = 0; inv_valid = 1; inv_line = 9'd80;
        @(negedge clk);
        check(2'b10, 2, "first of two");
        inv_valid = 0; repl_valid = 1; repl_line = 9'd81;
        @(negedge clk);
        check(2'b10, 3, "second of two");
        idle();
        @(negedge clk);
        check(2'b00, 8, "quiet after pair");
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule